// File: doc/BRIEF.md
# ALU with Registered Compare Flags

This block is the arithmetic and logic stage of a small 32-bit RISC core. On each cycle that `exec_en` is high it takes a 4-bit opcode and two operand words. Operand A comes from a register. Operand B is either a register or an immediate; that choice is made outside the block. It registers the result one clock later. The supported operations are add, subtract, AND, OR, XOR, NOT, an unsigned compare and a pseudo-random word generator.

Two sticky flags, zero and carry, sit in registers. They keep their values between instructions so that later conditional jumps can test them. They change only on an executed, flag-affecting operation while `flag_wr` is high.

A compare writes no register. It only sets the carry flag to mean "A is greater than B" and the zero flag to mean "A equals B". The random opcode returns the current state of an internal linear feedback shift register and then advances it, so each execution yields a fresh word.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcode 4'b1000 yields A+B (mod 2^32) with `res_wr`=1. When flags are written, C takes the carry out of bit 31 and Z is set when the 32-bit sum is zero.
- R2: Opcode 4'b1001 yields A-B (mod 2^32) with `res_wr`=1. When flags are written, C is the borrow (A<B, unsigned) and Z is set when the difference is zero.
- R3: Opcodes 4'b1010, 4'b1011 and 4'b1101 yield A AND B, A OR B and A XOR B, with `res_wr`=1. When flags are written, C is cleared and Z is set when the result is zero.
- R4: Opcode 4'b1100 yields the bitwise NOT of A, whatever the value of B. Flags follow the rule in R3.
- R5: Opcode 4'b1111 compares A and B as unsigned numbers. When flags are written, C=(A>B) and Z=(A==B). The result register reads 0 and `res_wr`=0.
- R6: Opcode 4'b1110 returns the current LFSR word with `res_wr`=1, then advances the LFSR one step. The LFSR shifts left; the new bit 0 is bit31^bit21^bit1^bit0, and the reset seed is 32'hACE1_2468. The LFSR does not move on any other cycle, and the random opcode leaves both flags unchanged.
- R7: Z and C change only on a cycle where `exec_en` and `flag_wr` are both high and the opcode is one of 1000, 1001, 1010, 1011, 1100, 1101, 1111.
- R8: While `rst` is high at a clock edge, `result` becomes 0, `res_wr` 0, Z 0, C 0, and the LFSR is reloaded with its seed.
- R9: Results appear one clock after the executing edge. On a cycle with `exec_en` low, `res_wr` goes to 0 and `result` keeps its last value.
- R10: Opcodes 4'b0000 to 4'b0111 are not ALU operations. Executing one of them gives `result`=0 and `res_wr`=0, and leaves the flags and the LFSR unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute the opcode on this cycle |
| flag_wr | input | 1 | Allow the executed opcode to update Z and C |
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (register or immediate) |
| result | output | 32 | Registered operation result |
| res_wr | output | 1 | Result is meant for register writeback |
| flag_z | output | 1 | Sticky zero / equal flag |
| flag_c | output | 1 | Sticky carry / borrow / greater-than flag |

## Verification
Flag state that is wrong inside the block does not stay hidden. A wrong Z or C shows on `flag_z`/`flag_c` the cycle after the faulty update. A stray update on a disabled or non-flag opcode also shows there, because the bench checks every cycle, idle ones included. A wrong LFSR step, seed or spurious advance stays invisible until the next random opcode. The bench therefore interleaves random opcodes with other work, so that a corrupted sequence shows in `result` within a few instructions. A carry wrongly tapped from the wrong bit appears only on overflowing sums, so the bench uses operands that wrap at both ends.

// File: rtl/aluf_pkg.sv
package aluf_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OPC_ADD = 4'b1000,
    OPC_SUB = 4'b1001,
    OPC_AND = 4'b1010,
    OPC_OR  = 4'b1011,
    OPC_NOT = 4'b1100,
    OPC_XOR = 4'b1101,
    OPC_RND = 4'b1110,
    OPC_CMP = 4'b1111
  } aluf_op_e;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_ARITH = 2'd1,
    FK_LOGIC = 2'd2,
    FK_CMP   = 2'd3
  } flag_kind_e;
endpackage

// File: rtl/aluf_addsub.sv
module aluf_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         cflag,
  output logic         a_gt_b,
  output logic         a_eq_b
);
  localparam int EW = W + 1;

  logic [W-1:0] b_eff;
  logic [EW-1:0] wide;
  logic carry_out;

  always_comb begin
    b_eff = do_sub ? ~b : b;
    wide = {1'b0, a} + {1'b0, b_eff} + {{(EW-1){1'b0}}, do_sub};
    sum = wide[W-1:0];
    carry_out = wide[W];
    // For subtraction the borrow is the inverted carry
    cflag = do_sub ? ~carry_out : carry_out;
    a_eq_b = (a == b);
    a_gt_b = do_sub & carry_out & ~a_eq_b;
  end
endmodule

// File: rtl/aluf_logic.sv
module aluf_logic #(
  parameter int W = 32
) (
  input  aluf_pkg::aluf_op_e op,
  input  logic [W-1:0]       a,
  input  logic [W-1:0]       b,
  output logic [W-1:0]       y
);
  import aluf_pkg::*;

  always_comb begin
    unique case (op)
      OPC_AND: y = a & b;
      OPC_OR:  y = a | b;
      OPC_XOR: y = a ^ b;
      OPC_NOT: y = ~a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/aluf_lfsr.sv
module aluf_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] SEED = 32'hACE1_2468,
  parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] word
);
  logic [W-1:0] state_q;
  logic fb;

  always_comb fb = ^(state_q & TAPS);

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else if (step) state_q <= {state_q[W-2:0], fb};
  end

  assign word = state_q;

  assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
  assert_lfsr_shift_R6: assert property (@(posedge clk) disable iff (rst)
    step |=> state_q[W-1:1] == $past(state_q[W-2:0]));
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int           DATA_W   = 32,
  parameter logic [31:0]  LFSR_SEED = 32'hACE1_2468,
  parameter logic [31:0]  LFSR_TAPS = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_en,
  input  logic              flag_wr,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              res_wr,
  output logic              flag_z,
  output logic              flag_c
);
  import aluf_pkg::*;

  aluf_op_e op;
  assign op = aluf_op_e'(op_code);

  logic [DATA_W-1:0] as_sum, lg_y, rnd_word, alu_y;
  logic as_c, as_gt, as_eq, do_sub, rnd_step, alu_wr;
  logic nz, nc, upd;
  flag_kind_e fk;

  aluf_addsub #(.W(DATA_W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .do_sub(do_sub),
    .sum(as_sum), .cflag(as_c), .a_gt_b(as_gt), .a_eq_b(as_eq)
  );

  aluf_logic #(.W(DATA_W)) u_logic (
    .op(op), .a(opnd_a), .b(opnd_b), .y(lg_y)
  );

  aluf_lfsr #(.W(DATA_W), .SEED(LFSR_SEED[DATA_W-1:0]), .TAPS(LFSR_TAPS[DATA_W-1:0])) u_lfsr (
    .clk(clk), .rst(rst), .step(rnd_step), .word(rnd_word)
  );

  // Compare runs through the subtractor
  assign do_sub = (op == OPC_SUB) || (op == OPC_CMP);
  assign rnd_step = exec_en && (op == OPC_RND);

  always_comb begin
    alu_y = '0;
    alu_wr = 1'b0;
    fk = FK_NONE;
    unique case (op)
      OPC_ADD, OPC_SUB: begin alu_y = as_sum; alu_wr = 1'b1; fk = FK_ARITH; end
      OPC_AND, OPC_OR, OPC_XOR, OPC_NOT: begin alu_y = lg_y; alu_wr = 1'b1; fk = FK_LOGIC; end
      OPC_RND: begin alu_y = rnd_word; alu_wr = 1'b1; end
      OPC_CMP: fk = FK_CMP;
      default: ;
    endcase
  end

  always_comb begin
    nz = flag_z;
    nc = flag_c;
    case (fk)
      FK_ARITH: begin nz = (as_sum == '0); nc = as_c; end
      FK_LOGIC: begin nz = (lg_y == '0); nc = 1'b0; end
      FK_CMP:   begin nz = as_eq; nc = as_gt; end
      default: ;
    endcase
  end

  assign upd = exec_en && flag_wr && (fk != FK_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      res_wr <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else begin
      res_wr <= exec_en && alu_wr;
      if (exec_en) result <= alu_y;
      if (upd) begin
        flag_z <= nz;
        flag_c <= nc;
      end
    end
  end

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(exec_en && flag_wr) |=> $stable({flag_z, flag_c}));
  assert_cmp_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    (exec_en && flag_wr && op == OPC_CMP) |=> !(flag_z && flag_c) && !res_wr);
  assert_logic_clears_c_R3: assert property (@(posedge clk) disable iff (rst)
    (exec_en && flag_wr && fk == FK_LOGIC) |=> !flag_c && (flag_z == (result == '0)));
  assert_arith_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (exec_en && flag_wr && fk == FK_ARITH) |=> flag_z == (result == '0));
  assert_lfsr_still_R6: assert property (@(posedge clk) disable iff (rst)
    !(exec_en && op == OPC_RND) |=> $stable(rnd_word));
  assert_idle_nowr_R9: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> !res_wr && $stable(result));
endmodule

// File: tb/test_alu_flag_unit.sv
`timescale 1ns/1ps
module test_alu_flag_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exec_en = 1'b0, flag_wr = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [31:0] result;
  logic res_wr, flag_z, flag_c;

  int n_checks = 0, n_errs = 0;
  bit finished = 1'b0;

  logic [31:0] q_res[$];
  logic q_wr[$], q_z[$], q_c[$];
  string q_tag[$];

  logic [31:0] m_res = '0, m_lfsr = 32'hACE1_2468;
  logic m_z = 1'b0, m_c = 1'b0;

  always #2 clk = ~clk;

  alu_flag_unit i_alu_flag_unit (
    .clk(clk), .rst(rst), .exec_en(exec_en), .flag_wr(flag_wr),
    .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .res_wr(res_wr), .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic push(input logic [31:0] r, input logic w, input string tag);
    q_res.push_back(r); q_wr.push_back(w);
    q_z.push_back(m_z); q_c.push_back(m_c); q_tag.push_back(tag);
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic fw, input string tag);
    logic [32:0] w33;
    logic [31:0] r;
    logic wr, nz, nc, fl;
    @(negedge clk);
    exec_en = 1'b1; flag_wr = fw; op_code = op; opnd_a = a; opnd_b = b;
    r = '0; wr = 1'b0; fl = 1'b0; nz = m_z; nc = m_c;
    case (op)
      4'b1000: begin w33 = {1'b0, a} + {1'b0, b}; r = w33[31:0]; wr = 1; fl = 1; nz = (r == 0); nc = w33[32]; end
      4'b1001: begin r = a - b; wr = 1; fl = 1; nz = (r == 0); nc = (a < b); end
      4'b1010: begin r = a & b; wr = 1; fl = 1; nz = (r == 0); nc = 0; end
      4'b1011: begin r = a | b; wr = 1; fl = 1; nz = (r == 0); nc = 0; end
      4'b1101: begin r = a ^ b; wr = 1; fl = 1; nz = (r == 0); nc = 0; end
      4'b1100: begin r = ~a; wr = 1; fl = 1; nz = (r == 0); nc = 0; end
      4'b1111: begin fl = 1; nz = (a == b); nc = (a > b); end
      4'b1110: begin
        r = m_lfsr; wr = 1;
        m_lfsr = {m_lfsr[30:0], m_lfsr[31] ^ m_lfsr[21] ^ m_lfsr[1] ^ m_lfsr[0]};
      end
      default: ;
    endcase
    if (fl && fw) begin m_z = nz; m_c = nc; end
    m_res = r;
    push(r, wr, tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    exec_en = 1'b0; flag_wr = 1'b1; op_code = 4'b1000; opnd_a = 32'h1; opnd_b = 32'h2;
    push(m_res, 1'b0, tag);
  endtask

  // Monitor: pops one expected item per queued cycle, just after the edge
  always @(posedge clk) begin
    #1;
    if (q_res.size() > 0) begin
      logic [31:0] er; logic ew, ez, ec; string t;
      er = q_res.pop_front(); ew = q_wr.pop_front();
      ez = q_z.pop_front(); ec = q_c.pop_front(); t = q_tag.pop_front();
      n_checks++;
      if (result !== er || res_wr !== ew || flag_z !== ez || flag_c !== ec) begin
        n_errs++;
        $display("FAIL %s: result=%h wr=%b z=%b c=%b expected result=%h wr=%b z=%b c=%b",
                 t, result, res_wr, flag_z, flag_c, er, ew, ez, ec);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (result !== 32'h0 || res_wr !== 1'b0 || flag_z !== 1'b0 || flag_c !== 1'b0) begin
      n_errs++;
      $display("FAIL R8: result=%h wr=%b z=%b c=%b expected 0 0 0 0", result, res_wr, flag_z, flag_c);
    end
    rst = 1'b0;
    @(negedge clk);

    issue(4'b1110, 32'h0, 32'h0, 1'b1, "R6");        // first word equals seed
    issue(4'b1000, 32'd5, 32'd7, 1'b1, "R1");
    issue(4'b1000, 32'hFFFF_FFFF, 32'h1, 1'b1, "R1");  // wrap: Z=1 C=1
    issue(4'b1000, 32'h8000_0000, 32'h8000_0001, 1'b1, "R1");
    issue(4'b1000, 32'h1, 32'h1, 1'b0, "R7");          // flags held
    issue(4'b1001, 32'd3, 32'd5, 1'b1, "R2");          // borrow
    issue(4'b1001, 32'd9, 32'd9, 1'b1, "R2");          // zero
    issue(4'b1001, 32'd10, 32'd4, 1'b1, "R2");
    issue(4'b1110, 32'h0, 32'h0, 1'b1, "R6");          // flags untouched
    issue(4'b1010, 32'hF0F0_1234, 32'h0F0F_4321, 1'b1, "R3");
    issue(4'b1010, 32'hF0F0_0000, 32'h0F0F_FFFF, 1'b1, "R3");
    issue(4'b1000, 32'hFFFF_FFFF, 32'h2, 1'b1, "R1");  // set C
    issue(4'b1011, 32'h0000_00A0, 32'h0000_000B, 1'b1, "R3"); // clears C
    issue(4'b1101, 32'h5A5A_5A5A, 32'h5A5A_5A5A, 1'b1, "R3");
    issue(4'b1100, 32'h1234_5678, 32'h0, 1'b1, "R4");
    issue(4'b1100, 32'h1234_5678, 32'hDEAD_BEEF, 1'b1, "R4");
    issue(4'b1100, 32'hFFFF_FFFF, 32'h7, 1'b1, "R4");
    issue(4'b1111, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R5"); // unsigned gt
    issue(4'b1111, 32'd4, 32'd9, 1'b1, "R5");
    issue(4'b1111, 32'hCAFE_0001, 32'hCAFE_0001, 1'b1, "R5");
    issue(4'b1111, 32'd100, 32'd1, 1'b0, "R7");
    idle("R9");
    idle("R9");
    issue(4'b0011, 32'h55, 32'h66, 1'b1, "R10");
    issue(4'b0000, 32'h0, 32'h0, 1'b1, "R10");
    issue(4'b0111, 32'hFFFF_FFFF, 32'h1, 1'b1, "R10");
    issue(4'b1110, 32'h0, 32'h0, 1'b0, "R6");
    idle("R9");
    issue(4'b1110, 32'h0, 32'h0, 1'b1, "R6");
    issue(4'b1110, 32'h0, 32'h0, 1'b1, "R6");
    issue(4'b1001, 32'h0, 32'h1, 1'b1, "R2");
    for (int k = 0; k < 6; k++) begin
      issue(4'b1000, 32'h1000_0000 * k, 32'hF000_0000, 1'b1, "R1");
      issue(4'b1110, 32'h0, 32'h0, 1'b1, "R6");
    end
    idle("R9");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule